// File: doc/BRIEF.md
# Time-Gated Two-Class Egress Arbiter

This block merges two classes of outgoing frames onto one transmit stream. Time-critical cyclic frames are held in their own queue and are released only while the schedule engine signals that the isochronous window is open. Best-effort acyclic frames sit in a second queue. They may start only outside the protected window and its guard band, only when the whole frame fits into the gap that remains before the protected region, and only when a per-cycle frame budget has a token left.

Frames move as beats with a last flag on a valid/ready stream. Once a frame has started it runs to its last beat, whatever the window signals do in the meantime. Upstream sources get an early backpressure flag on the acyclic side. Each class keeps a refused-beat counter and a peak-occupancy watermark. There are also a shaper hold counter and a counter for cyclic frames that missed their window.

Top module: `gated_egress_arbiter`

## Requirements
- R1: A cyclic frame starts only on a clock edge at which `win_iso` is 1. While `win_iso` is 0, no cyclic frame starts, even with frames queued.
- R2: An acyclic frame starts only when all of the following hold at that edge: `win_iso` is 0, `win_guard` is 0, the length field of its first beat is no greater than `win_gap`, and a budget token is available. `out_cyclic` is 1 exactly for beats taken from the cyclic queue, so acyclic data never leaves marked as cyclic.
- R3: A frame that has started continues beat by beat from the same queue until its beat with `last`=1, even if the windows change meanwhile.
- R4: The budget holds whole-frame tokens and is 0 after reset. Each `cycle_start` pulse adds `cfg_refill`, and the result saturates at `cfg_ceiling`. Each acyclic frame start consumes one token.
- R5: `limit_hit_cnt` rises by one for every clock in which an acyclic frame would be allowed to start except that no token is left.
- R6: `acy_backpressure` is 1 while the acyclic queue holds at least `cfg_bp_level` beats.
- R7: Each queue accepts a beat whenever it is not full (its ready is 1). Every beat offered while that queue is full is refused and raises that class's drop counter by one.
- R8: `cyc_peak` and `acy_peak` hold the largest occupancy each queue has reached since reset.
- R9: When `win_iso` falls while the cyclic queue holds beats and no cyclic frame is in flight, `cyc_late_cnt` rises by one. The waiting frame stays queued and leaves in the next window.
- R10: After reset, `out_valid` is 0, both input readies are 1, `acy_backpressure` is 0 and every counter and watermark is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_in_valid | input | 1 | Cyclic beat offered |
| cyc_in_ready | output | 1 | Cyclic queue not full |
| cyc_in_data | input | DW | Cyclic beat data |
| cyc_in_last | input | 1 | Last beat of cyclic frame |
| acy_in_valid | input | 1 | Acyclic beat offered |
| acy_in_ready | output | 1 | Acyclic queue not full |
| acy_in_data | input | DW | Acyclic beat data |
| acy_in_last | input | 1 | Last beat of acyclic frame |
| acy_in_len | input | LW | Acyclic frame length in beats, read from the first beat |
| acy_backpressure | output | 1 | Acyclic queue at or above threshold |
| win_iso | input | 1 | Isochronous window open |
| win_guard | input | 1 | Guard band ahead of the window |
| cycle_start | input | 1 | One-clock pulse at each cycle start |
| win_gap | input | LW | Clocks left before the protected region begins |
| cfg_refill | input | TW | Tokens added per cycle start |
| cfg_ceiling | input | TW | Token ceiling |
| cfg_bp_level | input | $clog2(DEPTH)+1 | Acyclic backpressure threshold |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts beat |
| out_data | output | DW | Output beat data |
| out_last | output | 1 | Last beat of output frame |
| out_cyclic | output | 1 | Output beat comes from the cyclic queue |
| cyc_drop_cnt | output | CW | Refused cyclic beats |
| acy_drop_cnt | output | CW | Refused acyclic beats |
| cyc_peak | output | $clog2(DEPTH)+1 | Cyclic occupancy watermark |
| acy_peak | output | $clog2(DEPTH)+1 | Acyclic occupancy watermark |
| limit_hit_cnt | output | CW | Clocks an acyclic frame was held by the budget |
| cyc_late_cnt | output | CW | Cyclic frames that missed a window |

## Verification
The bench queues cyclic frames with the window shut and checks that none leaves. A gate that acted only as a priority would let them through. It gives an acyclic frame one beat more than the remaining gap, and raises the guard band, to catch a fit check or guard test that is off by one or missing. It drains and refills the token budget across several cycle starts to expose a missing ceiling or an unconsumed token. It also closes the window in the middle of a cyclic frame, to catch a design that truncates the frame or miscounts it as late. A frame pushed in the last open clock must count as late and leave in the following window.

// File: rtl/gea_pkg.sv
package gea_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_CYC  = 2'd1,
    SEL_ACY  = 2'd2
  } sel_e;
endpackage

// File: rtl/gea_fifo.sv
module gea_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8,
  parameter int CW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int NW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic [NW-1:0] count,
  output logic [CW-1:0] drop_cnt,
  output logic [NW-1:0] peak
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push, do_pop;

  assign in_ready = (count != NW'(DEPTH));
  assign empty    = (count == '0);
  assign push     = in_valid && in_ready;
  assign do_pop   = pop && !empty;
  assign head     = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; count <= '0; drop_cnt <= '0; peak <= '0;
    end else begin
      if (push)   wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + NW'(push) - NW'(do_pop);
      if (in_valid && !in_ready) drop_cnt <= drop_cnt + 1'b1;
      if (count > peak) peak <= count;
    end
  end

  // R7
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> (drop_cnt == $past(drop_cnt) + 1'b1));
  // R8
  peak_cover_chk: assert property (@(posedge clk) disable iff (rst)
    peak >= $past(count));
endmodule

// File: rtl/gea_tokens.sv
module gea_tokens #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cycle_start,
  input  logic          take,
  input  logic [TW-1:0] refill,
  input  logic [TW-1:0] ceiling,
  output logic          avail
);
  logic [TW-1:0] tokens;
  logic [TW:0]   nxt;

  always_comb begin
    nxt = {1'b0, tokens};
    if (take && tokens != '0) nxt = nxt - 1'b1;
    if (cycle_start) nxt = nxt + {1'b0, refill};
    if (nxt > {1'b0, ceiling}) nxt = {1'b0, ceiling};
  end

  always_ff @(posedge clk) begin
    if (rst) tokens <= '0;
    else     tokens <= nxt[TW-1:0];
  end

  assign avail = (tokens != '0);

  // R4
  token_ceil_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> (tokens <= $past(ceiling)));
endmodule

// File: rtl/gated_egress_arbiter.sv
module gated_egress_arbiter
  import gea_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int LW    = 8,
  parameter int TW    = 4,
  parameter int CW    = 16,
  localparam int NW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_in_valid,
  output logic          cyc_in_ready,
  input  logic [DW-1:0] cyc_in_data,
  input  logic          cyc_in_last,
  input  logic          acy_in_valid,
  output logic          acy_in_ready,
  input  logic [DW-1:0] acy_in_data,
  input  logic          acy_in_last,
  input  logic [LW-1:0] acy_in_len,
  output logic          acy_backpressure,
  input  logic          win_iso,
  input  logic          win_guard,
  input  logic          cycle_start,
  input  logic [LW-1:0] win_gap,
  input  logic [TW-1:0] cfg_refill,
  input  logic [TW-1:0] cfg_ceiling,
  input  logic [NW-1:0] cfg_bp_level,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          out_cyclic,
  output logic [CW-1:0] cyc_drop_cnt,
  output logic [CW-1:0] acy_drop_cnt,
  output logic [NW-1:0] cyc_peak,
  output logic [NW-1:0] acy_peak,
  output logic [CW-1:0] limit_hit_cnt,
  output logic [CW-1:0] cyc_late_cnt
);
  localparam int CQW = DW + 1;
  localparam int AQW = DW + 1 + LW;

  logic [CQW-1:0] cyc_head;
  logic [AQW-1:0] acy_head;
  logic           cyc_empty, acy_empty, cyc_pop, acy_pop;
  logic [NW-1:0]  cyc_count, acy_count;
  logic           tok_avail, tok_take, cyc_go, acy_ok, acy_go, win_iso_q;
  logic [LW-1:0]  acy_head_len;
  sel_e           sel_q;

  gea_fifo #(.W(CQW), .DEPTH(DEPTH), .CW(CW)) u_cyc_q (
    .clk(clk), .rst(rst), .in_valid(cyc_in_valid), .in_ready(cyc_in_ready),
    .in_data({cyc_in_last, cyc_in_data}), .pop(cyc_pop), .head(cyc_head),
    .empty(cyc_empty), .count(cyc_count), .drop_cnt(cyc_drop_cnt), .peak(cyc_peak));

  gea_fifo #(.W(AQW), .DEPTH(DEPTH), .CW(CW)) u_acy_q (
    .clk(clk), .rst(rst), .in_valid(acy_in_valid), .in_ready(acy_in_ready),
    .in_data({acy_in_len, acy_in_last, acy_in_data}), .pop(acy_pop), .head(acy_head),
    .empty(acy_empty), .count(acy_count), .drop_cnt(acy_drop_cnt), .peak(acy_peak));

  gea_tokens #(.TW(TW)) u_tokens (
    .clk(clk), .rst(rst), .cycle_start(cycle_start), .take(tok_take),
    .refill(cfg_refill), .ceiling(cfg_ceiling), .avail(tok_avail));

  assign acy_head_len     = acy_head[AQW-1 -: LW];
  assign acy_backpressure = (acy_count >= cfg_bp_level);

  // Start decisions: hard time gate for cyclic, budget plus fit for acyclic.
  assign cyc_go   = win_iso && !cyc_empty;
  assign acy_ok   = !acy_empty && !win_iso && !win_guard && (acy_head_len <= win_gap);
  assign acy_go   = !cyc_go && acy_ok && tok_avail;
  assign tok_take = (sel_q == SEL_IDLE) && acy_go;

  always_comb begin
    out_valid  = 1'b0;
    out_data   = '0;
    out_last   = 1'b0;
    out_cyclic = 1'b0;
    if (sel_q == SEL_CYC) begin
      out_valid  = !cyc_empty;
      out_data   = cyc_head[DW-1:0];
      out_last   = cyc_head[DW];
      out_cyclic = 1'b1;
    end else if (sel_q == SEL_ACY) begin
      out_valid  = !acy_empty;
      out_data   = acy_head[DW-1:0];
      out_last   = acy_head[DW];
    end
  end

  assign cyc_pop = (sel_q == SEL_CYC) && out_valid && out_ready;
  assign acy_pop = (sel_q == SEL_ACY) && out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_IDLE;
    end else begin
      case (sel_q)
        SEL_IDLE: if (cyc_go) sel_q <= SEL_CYC;
                  else if (acy_go) sel_q <= SEL_ACY;
        SEL_CYC:  if (cyc_pop && out_last) sel_q <= SEL_IDLE;
        SEL_ACY:  if (acy_pop && out_last) sel_q <= SEL_IDLE;
        default:  sel_q <= SEL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_iso_q     <= 1'b0;
      limit_hit_cnt <= '0;
      cyc_late_cnt  <= '0;
    end else begin
      win_iso_q <= win_iso;
      if (sel_q == SEL_IDLE && !cyc_go && acy_ok && !tok_avail)
        limit_hit_cnt <= limit_hit_cnt + 1'b1;
      if (win_iso_q && !win_iso && !cyc_empty && sel_q != SEL_CYC)
        cyc_late_cnt <= cyc_late_cnt + 1'b1;
    end
  end

  // R1
  cyc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_CYC && $past(sel_q) == SEL_IDLE) |-> $past(win_iso));
  // R2
  acy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_ACY && $past(sel_q) == SEL_IDLE)
      |-> $past(!win_iso && !win_guard && tok_avail && acy_head_len <= win_gap));
  // R3
  no_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_CYC && !(cyc_pop && out_last)) |=> (sel_q == SEL_CYC));
  // R3
  no_cut_acy_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_ACY && !(acy_pop && out_last)) |=> (sel_q == SEL_ACY));
endmodule

// File: tb/gated_egress_arbiter_tb.sv
module gated_egress_arbiter_tb;
  localparam int DW = 8, DEPTH = 8, LW = 8, TW = 4, CW = 16, NW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc_in_valid = 0, cyc_in_ready, cyc_in_last = 0;
  logic [DW-1:0] cyc_in_data = '0;
  logic acy_in_valid = 0, acy_in_ready, acy_in_last = 0;
  logic [DW-1:0] acy_in_data = '0;
  logic [LW-1:0] acy_in_len = '0;
  logic acy_backpressure, win_iso = 0, win_guard = 0, cycle_start = 0;
  logic [LW-1:0] win_gap = '0;
  logic [TW-1:0] cfg_refill = '0, cfg_ceiling = '0;
  logic [NW-1:0] cfg_bp_level = NW'(DEPTH);
  logic out_valid, out_ready = 1'b1, out_last, out_cyclic;
  logic [DW-1:0] out_data;
  logic [CW-1:0] cyc_drop_cnt, acy_drop_cnt, limit_hit_cnt, cyc_late_cnt;
  logic [NW-1:0] cyc_peak, acy_peak;

  int total = 0, bad = 0;
  int n_cyc = 0, n_acy = 0, viol = 0, lasts = 0;
  bit in_frame = 0, iso_prev = 0, grd_prev = 0, done = 0;

  always #2.5 clk = ~clk;

  gated_egress_arbiter u_dut (.*);

  // Output monitor: samples after drivers settle, before the next rising edge.
  always begin
    @(negedge clk); #1;
    if (!rst && out_valid && out_ready) begin
      if (out_cyclic) n_cyc++; else n_acy++;
      if (out_cyclic != out_data[7]) viol++;
      if (!in_frame && out_cyclic && !iso_prev) viol++;
      if (!in_frame && !out_cyclic && (iso_prev || grd_prev)) viol++;
      if (out_last) lasts++;
      in_frame = !out_last;
    end
    iso_prev = win_iso;
    grd_prev = win_guard;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cyc_in_valid = 0; acy_in_valid = 0; win_iso = 0; win_guard = 0;
    cycle_start = 0; win_gap = 8'd100; cfg_refill = 0; cfg_ceiling = 0;
    cfg_bp_level = NW'(DEPTH);
    repeat (3) @(negedge clk);
    rst = 0;
    n_cyc = 0; n_acy = 0; viol = 0; lasts = 0; in_frame = 0;
  endtask

  task automatic push_cyc(input logic [6:0] d, input logic last);
    @(negedge clk);
    cyc_in_valid = 1; cyc_in_data = {1'b1, d}; cyc_in_last = last;
    @(negedge clk);
    cyc_in_valid = 0;
  endtask

  task automatic push_acy(input logic [6:0] d, input logic last, input logic [LW-1:0] len);
    @(negedge clk);
    acy_in_valid = 1; acy_in_data = {1'b0, d}; acy_in_last = last; acy_in_len = len;
    @(negedge clk);
    acy_in_valid = 0;
  endtask

  task automatic pulse_cycle();
    @(negedge clk); cycle_start = 1;
    @(negedge clk); cycle_start = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(out_valid == 0, "R10 out_valid", out_valid, 0);
    check(cyc_in_ready && acy_in_ready, "R10 readies", {cyc_in_ready, acy_in_ready}, 3);
    check(acy_backpressure == 0, "R10 backpressure", acy_backpressure, 0);
    check(cyc_drop_cnt == 0 && acy_drop_cnt == 0 && limit_hit_cnt == 0 && cyc_late_cnt == 0
          && cyc_peak == 0 && acy_peak == 0, "R10 counters", int'(limit_hit_cnt), 0);
  endtask

  task automatic t_cyc_gate();
    do_reset();
    push_cyc(7'd1, 0); push_cyc(7'd2, 1);
    wait_n(10);
    check(n_cyc == 0, "R1 held while window shut", n_cyc, 0);
    win_iso = 1; wait_n(6); win_iso = 0; wait_n(2);
    check(n_cyc == 2 && lasts == 1, "R1 released in window", n_cyc, 2);
    check(viol == 0, "R1 start only in window", viol, 0);
  endtask

  task automatic t_late();
    do_reset();
    @(negedge clk); win_iso = 1; cyc_in_valid = 1; cyc_in_data = 8'h85; cyc_in_last = 1;
    @(negedge clk); cyc_in_valid = 0; win_iso = 0;
    wait_n(4);
    check(cyc_late_cnt == 1, "R9 late count", cyc_late_cnt, 1);
    check(n_cyc == 0, "R9 frame kept queued", n_cyc, 0);
    win_iso = 1; wait_n(4); win_iso = 0; wait_n(2);
    check(n_cyc == 1, "R9 sent next window", n_cyc, 1);
  endtask

  task automatic t_no_cut();
    do_reset();
    push_cyc(7'd3, 0); push_cyc(7'd4, 0); push_cyc(7'd5, 1);
    @(negedge clk); win_iso = 1;
    @(negedge clk); win_iso = 0;
    wait_n(8);
    check(n_cyc == 3 && lasts == 1, "R3 frame completes after window close", n_cyc, 3);
    check(cyc_late_cnt == 0, "R9 in-flight frame not late", cyc_late_cnt, 0);
    check(viol == 0, "R2 class marking", viol, 0);
  endtask

  task automatic t_budget();
    do_reset();
    cfg_refill = 4'd2; cfg_ceiling = 4'd3;
    for (int i = 0; i < 4; i++) push_acy(7'(10 + i), 1, 8'd1);
    wait_n(3);
    check(n_acy == 0, "R4 no tokens after reset", n_acy, 0);
    check(limit_hit_cnt > 0, "R5 limit hits counted", limit_hit_cnt, 1);
    pulse_cycle(); wait_n(10);
    check(n_acy == 2, "R4 refill grants two frames", n_acy, 2);
    do_reset();
    cfg_refill = 4'd2; cfg_ceiling = 4'd3;
    pulse_cycle(); pulse_cycle(); pulse_cycle();
    for (int i = 0; i < 5; i++) push_acy(7'(20 + i), 1, 8'd1);
    wait_n(20);
    check(n_acy == 3, "R4 ceiling caps burst", n_acy, 3);
    check(viol == 0, "R2 acyclic outside window", viol, 0);
  endtask

  task automatic t_fit_guard();
    do_reset();
    cfg_refill = 4'd1; cfg_ceiling = 4'd1; pulse_cycle();
    win_gap = 8'd3;
    for (int i = 0; i < 4; i++) push_acy(7'(30 + i), (i == 3), 8'd4);
    wait_n(10);
    check(n_acy == 0, "R2 frame longer than gap held", n_acy, 0);
    win_gap = 8'd4; wait_n(10);
    check(n_acy == 4, "R2 frame that fits sent", n_acy, 4);
    do_reset();
    cfg_refill = 4'd1; cfg_ceiling = 4'd1; pulse_cycle();
    win_guard = 1;
    push_acy(7'd40, 1, 8'd1);
    wait_n(8);
    check(n_acy == 0, "R2 guard band blocks", n_acy, 0);
    win_guard = 0; win_iso = 1; wait_n(8);
    check(n_acy == 0, "R2 window blocks acyclic", n_acy, 0);
    win_iso = 0; wait_n(6);
    check(n_acy == 1 && viol == 0, "R2 sent after guard", n_acy, 1);
  endtask

  task automatic t_queues();
    do_reset();
    cfg_bp_level = 4'd3;
    push_acy(7'd50, 1, 8'd1); push_acy(7'd51, 1, 8'd1);
    check(acy_backpressure == 0, "R6 below threshold", acy_backpressure, 0);
    push_acy(7'd52, 1, 8'd1);
    check(acy_backpressure == 1, "R6 at threshold", acy_backpressure, 1);
    for (int i = 0; i < 5; i++) push_acy(7'(53 + i), 1, 8'd1);
    check(acy_in_ready == 0, "R7 acyclic full", acy_in_ready, 0);
    push_acy(7'd60, 1, 8'd1); push_acy(7'd61, 1, 8'd1);
    wait_n(2);
    check(acy_drop_cnt == 2, "R7 acyclic drops", acy_drop_cnt, 2);
    check(acy_peak == NW'(DEPTH), "R8 acyclic peak", acy_peak, DEPTH);
    for (int i = 0; i < DEPTH + 1; i++) push_cyc(7'(i), 1);
    wait_n(2);
    check(cyc_drop_cnt == 1, "R7 cyclic drops", cyc_drop_cnt, 1);
    check(cyc_peak == NW'(DEPTH), "R8 cyclic peak", cyc_peak, DEPTH);
    check(n_acy == 0 && n_cyc == 0, "R7 nothing sent while held", n_acy + n_cyc, 0);
  endtask

  initial begin
    t_reset();
    t_cyc_gate();
    t_late();
    t_no_cut();
    t_budget();
    t_fit_guard();
    t_queues();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule